// File: doc/BRIEF.md
# Pseudo-Random Test Pattern Generator

This block is a parameterized linear feedback shift register that drives stimulus in built-in self-test. Each enabled clock moves the register to its next state, and the whole state goes out in parallel. The last stage also goes out as a single serial bit that can feed a scan chain. A parameter picks the feedback arrangement. In the external form, one XOR tree computes the bit that enters the first stage. In the internal form, an XOR sits between two stages at every nonzero coefficient of the polynomial.

The polynomial is a parameter vector. Bit k holds the coefficient of x^k, and both bit 0 and bit WIDTH must be 1. With a primitive polynomial the register steps through every nonzero pattern once per period of 2^n - 1. A second parameter splices the all-zero pattern into that cycle, so the register then visits all 2^n patterns. A seed can be loaded at any time to start a new sequence. A zero seed is replaced by 1 when the register could never leave the zero state.

The state vector is numbered so that bit 0 is stage 1, which is the stage the external form feeds. Bit WIDTH-1 is stage n, the last stage.

Top module: `prpg_lfsr`

## Requirements
- R1: While reset is active and after it is released, the state is 1 (only bit 0 set), and no step happens until an enable or a load arrives.
- R2: External form: on an enabled step, bit j+1 takes the old bit j. Bit 0 takes the XOR of old bit WIDTH-1-k over every k below WIDTH with POLY[k] = 1. For x^3+x+1 starting from 3'b100 the states are 1, 2, 5, 3, 7, 6, and then 4 again.
- R3: Internal form: on an enabled step, bit 0 takes old bit WIDTH-1. Each bit j >= 1 takes old bit j-1 XOR (old bit WIDTH-1 AND POLY[j]). This is the state multiplied by x modulo the polynomial.
- R4: When the zero extension is off and the polynomial is primitive, the period is exactly 2^WIDTH - 1. Every nonzero state appears once per period, and the state is never zero.
- R5: When the zero extension is on, the feedback bit is inverted whenever bits 0 to WIDTH-2 are all zero. The period becomes 2^WIDTH and all states appear once, including zero. The state after zero is 1 in the external form and POLY[WIDTH-1:0] in the internal form.
- R6: With enable low and load low, the state does not change.
- R7: Load takes priority over enable. On the clock after load, the state equals the seed, whatever the enable is.
- R8: A zero seed loads as 1 when the zero extension is off, and loads as 0 when it is on.
- R9: The serial output always equals state bit WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_en_i | input | 1 | Advance the sequence by one state |
| seed_ld_i | input | 1 | Load seed_i as the next state |
| seed_i | input | WIDTH | Seed value |
| state_o | output | WIDTH | Parallel pattern, bit 0 is stage 1 |
| serial_o | output | 1 | Last stage, serial pattern bit |

## Verification
Both forms are walked through full periods for 3, 5 and 8 stages, with and without the zero extension. Each step is compared with a next state computed from the polynomial arithmetic. This separates a wrong tap position, a wrong tap direction and a misplaced zero splice, because each of those shortens the period, repeats a state or breaks a single step. The 3-stage external run also follows the fixed example sequence from 3'b100.

The 16- and 32-stage polynomials are walked for a few hundred steps. This catches faults that only appear when the taps are far apart.

Seed patterns 0, 1 and a mixed value, together with enable-low holds, show load priority, the zero-seed substitution and state retention.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

   typedef enum logic {
      FORM_EXTERNAL = 1'b0,
      FORM_INTERNAL = 1'b1
   } fb_form_e;

endpackage

// File: rtl/lfsr_next_ext.sv
module lfsr_next_ext #(
   parameter int unsigned      WIDTH    = 8,
   parameter logic [WIDTH:0]   POLY     = 9'h163,
   parameter bit               ZERO_EXT = 1'b0
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] nxt_o
);

   // tap_mask bit (WIDTH-1-k) selects stage for coefficient x^k
   logic [WIDTH-1:0] tap_mask;
   logic             low_zero;
   logic             fb;

   for (genvar k = 0; k < WIDTH; k++) begin : g_tap
      assign tap_mask[WIDTH-1-k] = POLY[k];
   end

   assign low_zero = (cur_i[WIDTH-2:0] == '0);

   always_comb begin
      fb = ^(cur_i & tap_mask);
      if (ZERO_EXT && low_zero) begin
         fb = ~fb;
      end
      nxt_o = {cur_i[WIDTH-2:0], fb};
   end

endmodule

// File: rtl/lfsr_next_int.sv
module lfsr_next_int #(
   parameter int unsigned      WIDTH    = 8,
   parameter logic [WIDTH:0]   POLY     = 9'h163,
   parameter bit               ZERO_EXT = 1'b0
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] nxt_o
);

   logic low_zero;
   logic fb;

   assign low_zero = (cur_i[WIDTH-2:0] == '0);
   assign fb       = cur_i[WIDTH-1] ^ (ZERO_EXT & low_zero);
   assign nxt_o[0] = fb;

   for (genvar j = 1; j < WIDTH; j++) begin : g_stage
      if (POLY[j]) begin : g_xor
         assign nxt_o[j] = cur_i[j-1] ^ fb;
      end else begin : g_wire
         assign nxt_o[j] = cur_i[j-1];
      end
   end

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
   parameter int unsigned WIDTH    = 8,
   parameter bit          ZERO_EXT = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_en_i,
   input  logic             seed_ld_i,
   input  logic [WIDTH-1:0] seed_i,
   input  logic [WIDTH-1:0] nxt_i,
   output logic [WIDTH-1:0] state_o
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] seed_fix;

   always_comb begin
      seed_fix = seed_i;
      if (!ZERO_EXT && (seed_i == '0)) begin
         seed_fix = ONE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_o <= ONE;
      end else if (seed_ld_i) begin
         state_o <= seed_fix;
      end else if (step_en_i) begin
         state_o <= nxt_i;
      end
   end

   p_hold_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_en_i && !seed_ld_i) |=> $stable(state_o));

   p_load_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seed_ld_i && (seed_i != '0)) |=> (state_o == $past(seed_i)));

   if (!ZERO_EXT) begin : g_zs
      p_zero_seed_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (seed_ld_i && (seed_i == '0)) |=> (state_o == ONE));
   end else begin : g_zk
      p_zero_seed_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (seed_ld_i && (seed_i == '0)) |=> (state_o == '0));
   end

endmodule

// File: rtl/prpg_lfsr.sv
module prpg_lfsr #(
   parameter int unsigned        WIDTH    = 8,
   parameter logic [WIDTH:0]     POLY     = 9'h163,
   parameter lfsr_pkg::fb_form_e FORM     = lfsr_pkg::FORM_EXTERNAL,
   parameter bit                 ZERO_EXT = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_en_i,
   input  logic             seed_ld_i,
   input  logic [WIDTH-1:0] seed_i,
   output logic [WIDTH-1:0] state_o,
   output logic             serial_o
);

   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_chk_w
      $error("prpg_lfsr: WIDTH must be at least 2");
   end
   if (POLY[WIDTH] != 1'b1 || POLY[0] != 1'b1) begin : g_chk_p
      $error("prpg_lfsr: POLY needs x^WIDTH and x^0 terms");
   end

   logic [WIDTH-1:0] nxt;
   logic             advance;

   if (FORM == lfsr_pkg::FORM_EXTERNAL) begin : g_ext
      lfsr_next_ext #(.WIDTH(WIDTH), .POLY(POLY), .ZERO_EXT(ZERO_EXT)) u_next (
         .cur_i (state_o),
         .nxt_o (nxt)
      );
   end else begin : g_int
      lfsr_next_int #(.WIDTH(WIDTH), .POLY(POLY), .ZERO_EXT(ZERO_EXT)) u_next (
         .cur_i (state_o),
         .nxt_o (nxt)
      );
   end

   lfsr_state_reg #(.WIDTH(WIDTH), .ZERO_EXT(ZERO_EXT)) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_en_i (step_en_i),
      .seed_ld_i (seed_ld_i),
      .seed_i    (seed_i),
      .nxt_i     (nxt),
      .state_o   (state_o)
   );

   assign serial_o = state_o[MSB];
   assign advance  = step_en_i && !seed_ld_i;

   if (FORM == lfsr_pkg::FORM_EXTERNAL) begin : g_a_ext
      p_ext_shift_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         advance |=> (state_o[MSB:1] == $past(state_o[MSB-1:0])));
   end else begin : g_a_int
      p_int_feed_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         advance |=> (state_o[0] == ($past(state_o[MSB]) ^
                      (ZERO_EXT && ($past(state_o[MSB-1:0]) == '0)))));
   end

   if (!ZERO_EXT) begin : g_a_nz
      p_nonzero_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         state_o != '0);
   end else begin : g_a_z
      p_zero_exit_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (advance && (state_o == '0)) |=> (state_o[0] == 1'b1));
   end

endmodule

// File: tb/prpg_lfsr_sweep.sv
module prpg_lfsr_sweep #(
   parameter int unsigned        W        = 3,
   parameter logic [W:0]         POLY     = 4'hB,
   parameter lfsr_pkg::fb_form_e FORM     = lfsr_pkg::FORM_EXTERNAL,
   parameter bit                 ZEXT     = 1'b0,
   parameter bit                 FULL     = 1'b1,
   parameter bit                 EXAMPLE  = 1'b0
) (
   input  logic clk,
   input  logic go,
   output logic done,
   output int   checks,
   output int   fails
);

   localparam int SB = (W <= 10) ? W : 1;

   logic         en, ld;
   logic [W-1:0] seed;
   logic [W-1:0] st;
   logic         so;
   logic         rst_n;
   logic         seen [0:(1<<SB)-1];

   prpg_lfsr #(.WIDTH(W), .POLY(POLY), .FORM(FORM), .ZERO_EXT(ZEXT)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .step_en_i(en), .seed_ld_i(ld),
      .seed_i(seed), .state_o(st), .serial_o(so)
   );

   function automatic logic [W-1:0] next_of(input logic [W-1:0] s);
      logic          b;
      logic [W-1:0]  r;
      logic          z;
      z = (s[W-2:0] == '0) && ZEXT;
      if (FORM == lfsr_pkg::FORM_EXTERNAL) begin
         b = z;
         for (int k = 0; k < W; k++) if (POLY[k]) b = b ^ s[W-1-k];
         r = {s[W-2:0], b};
      end else begin
         b = s[W-1] ^ z;
         r = s << 1;
         if (b) r = r ^ POLY[W-1:0];
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s W=%0d form=%0d zext=%0d: actual %0h expected %0h",
                  req, W, FORM, ZEXT, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(input logic [W-1:0] v);
      ld = 1'b1; seed = v; tick(); ld = 1'b0;
   endtask

   initial begin
      logic [W-1:0] s, start, ex;
      int           distinct, period;
      logic [W-1:0] ref_seq [0:6];
      en = 0; ld = 0; seed = '0; done = 0; checks = 0; fails = 0; rst_n = 0;
      for (int i = 0; i < (1<<SB); i++) seen[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      wait (go);
      @(negedge clk);
      // R1 reset value, R9 serial
      chk(st == W'(1), "R1", 64'(st), 64'(1));
      chk(so == st[W-1], "R9", 64'(so), 64'(st[W-1]));
      // R6 hold with enable low
      repeat (3) tick();
      chk(st == W'(1), "R6", 64'(st), 64'(1));
      // R7 load with enable low, then load beats enable
      load(W'(5));
      chk(st == W'(5), "R7", 64'(st), 64'(5));
      en = 1; load(W'(3)); en = 0;
      chk(st == W'(3), "R7", 64'(st), 64'(3));
      // R8 zero seed
      load('0);
      ex = ZEXT ? '0 : W'(1);
      chk(st == ex, "R8", 64'(st), 64'(ex));
      if (ZEXT) begin
         en = 1; tick(); en = 0;
         ex = (FORM == lfsr_pkg::FORM_EXTERNAL) ? W'(1) : POLY[W-1:0];
         chk(st == ex, "R5", 64'(st), 64'(ex));
      end
      // R2 fixed example for x^3+x+1 external
      if (EXAMPLE) begin
         ref_seq[0] = W'(1); ref_seq[1] = W'(2); ref_seq[2] = W'(5);
         ref_seq[3] = W'(3); ref_seq[4] = W'(7); ref_seq[5] = W'(6);
         ref_seq[6] = W'(4);
         load(W'(4));
         en = 1;
         for (int i = 0; i < 7; i++) begin
            tick();
            chk(st == ref_seq[i], "R2", 64'(st), 64'(ref_seq[i]));
         end
         en = 0;
      end
      // main walk: R2/R3 step, R4/R5 period and coverage, R9 serial
      load(W'(1));
      start = st;
      s = st;
      period = FULL ? ((1 << SB) - (ZEXT ? 0 : 1)) : 300;
      distinct = 0;
      en = 1;
      for (int i = 0; i < period; i++) begin
         if (FULL) begin
            if (!seen[SB'(s)]) distinct++;
            seen[SB'(s)] = 1'b1;
         end
         ex = next_of(s);
         tick();
         chk(st == ex, (FORM == lfsr_pkg::FORM_EXTERNAL) ? "R2" : "R3",
             64'(st), 64'(ex));
         chk(so == st[W-1], "R9", 64'(so), 64'(st[W-1]));
         if (!ZEXT) chk(st != '0, "R4", 64'(st), 64'(1));
         s = ex;
      end
      en = 0;
      if (FULL) begin
         chk(st == start, ZEXT ? "R5" : "R4", 64'(st), 64'(start));
         chk(distinct == period, ZEXT ? "R5" : "R4", 64'(distinct), 64'(period));
         chk(seen[0] == ZEXT, ZEXT ? "R5" : "R4", 64'(seen[0]), 64'(ZEXT));
      end
      tick();
      chk(st == s, "R6", 64'(st), 64'(s));
      done = 1;
   end

endmodule

// File: tb/prpg_lfsr_tb_top.sv
module prpg_lfsr_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic go [0:7];
   logic dn [0:7];
   int   ck [0:7];
   int   fl [0:7];

   prpg_lfsr_sweep #(.W(3), .POLY(4'hB), .FORM(lfsr_pkg::FORM_EXTERNAL),
      .ZEXT(1'b0), .FULL(1'b1), .EXAMPLE(1'b1)) u0 (clk, go[0], dn[0], ck[0], fl[0]);
   prpg_lfsr_sweep #(.W(3), .POLY(4'hB), .FORM(lfsr_pkg::FORM_INTERNAL),
      .ZEXT(1'b1), .FULL(1'b1), .EXAMPLE(1'b0)) u1 (clk, go[1], dn[1], ck[1], fl[1]);
   prpg_lfsr_sweep #(.W(5), .POLY(6'h25), .FORM(lfsr_pkg::FORM_INTERNAL),
      .ZEXT(1'b0), .FULL(1'b1), .EXAMPLE(1'b0)) u2 (clk, go[2], dn[2], ck[2], fl[2]);
   prpg_lfsr_sweep #(.W(5), .POLY(6'h25), .FORM(lfsr_pkg::FORM_EXTERNAL),
      .ZEXT(1'b1), .FULL(1'b1), .EXAMPLE(1'b0)) u3 (clk, go[3], dn[3], ck[3], fl[3]);
   prpg_lfsr_sweep #(.W(8), .POLY(9'h163), .FORM(lfsr_pkg::FORM_EXTERNAL),
      .ZEXT(1'b0), .FULL(1'b1), .EXAMPLE(1'b0)) u4 (clk, go[4], dn[4], ck[4], fl[4]);
   prpg_lfsr_sweep #(.W(8), .POLY(9'h163), .FORM(lfsr_pkg::FORM_INTERNAL),
      .ZEXT(1'b1), .FULL(1'b1), .EXAMPLE(1'b0)) u5 (clk, go[5], dn[5], ck[5], fl[5]);
   prpg_lfsr_sweep #(.W(16), .POLY(17'h1002D), .FORM(lfsr_pkg::FORM_INTERNAL),
      .ZEXT(1'b0), .FULL(1'b0), .EXAMPLE(1'b0)) u6 (clk, go[6], dn[6], ck[6], fl[6]);
   prpg_lfsr_sweep #(.W(32), .POLY(33'h1_1800_0003), .FORM(lfsr_pkg::FORM_EXTERNAL),
      .ZEXT(1'b0), .FULL(1'b0), .EXAMPLE(1'b0)) u7 (clk, go[7], dn[7], ck[7], fl[7]);

   int  total_checks;
   int  total_fails;
   bit  timed_out = 1'b0;

   task automatic report();
      total_checks = 0;
      total_fails  = 0;
      for (int i = 0; i < 8; i++) begin
         total_checks += ck[i];
         total_fails  += fl[i];
      end
      if (timed_out) begin
         total_checks++;
         total_fails++;
      end
      $display("End of test - %0d assertions evaluated, %0d failures",
               total_checks, total_fails);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) go[i] = 1'b0;
      repeat (6) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         go[i] = 1'b1;
         wait (dn[i]);
         @(negedge clk);
      end
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      timed_out = 1'b1;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      report();
   end

endmodule